// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two single-precision floating-point operands and stores a one-bit condition flag that later conditional branches test: branch-if-false takes the branch when the flag is 0, and branch-if-true takes it when the flag is 1. A 4-bit condition field selects which relations set the flag. The three relations are "first operand below second", "operands equal" and "operands unordered". The flag is the OR of the selected relations.

The comparison is unordered when either operand is a NaN. In that case the below and equal relations are both false. The condition field also carries a signalling bit. When the signalling bit is set and the operands are unordered, the unit raises a one-cycle invalid-operation pulse instead of updating the flag. Results appear one clock after a valid strobe, and the flag holds its value between strobes.

Top module: `fp_cmp_flag`

## Requirements
- R1: While reset is active and after its release, before any strobe, `cond_flag` and `invalid_pulse` are both 0.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero. Infinities are not NaNs. A NaN on either side makes the comparison unordered.
- R3: For operands that are not NaNs, "below" follows numeric order from sign and magnitude. A negative value is below any positive value. Among negative values, the larger magnitude is below. Infinities sit at the ends of the order.
- R4: Positive zero and negative zero compare equal, and neither is below the other.
- R5: The new flag value is (cond[2] AND below) OR (cond[1] AND equal) OR (cond[0] AND unordered). A field whose low three bits are 0 yields a flag of 0.
- R6: When cond[3] is 1 and the comparison is unordered, `invalid_pulse` is 1 in the cycle after the strobe, and `cond_flag` keeps its previous value.
- R7: When cond[3] is 1 and the operands are ordered, no invalid pulse occurs and the flag updates as in R5.
- R8: The flag changes only on the clock edge that samples `op_valid` high. It becomes visible the cycle after the strobe and is held while `op_valid` is low.
- R9: `invalid_pulse` is high for exactly one cycle per trapping strobe, and is low in any cycle not preceded by a trapping strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: evaluate the operands and field on this edge |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| cond | input | 4 | bit0 unordered, bit1 equal, bit2 below, bit3 signalling |
| cond_flag | output | 1 | Registered condition flag for branch decisions |
| invalid_pulse | output | 1 | One-cycle invalid-operation indication |

## Verification
The flag is the only state in the unit. If it were wrong, the fault would show at `cond_flag` in the very next cycle after the strobe and would persist until the next update. For that reason, each scenario reads the flag one cycle after its strobe and again one cycle later, which catches both wrong values and unwanted changes. A trap that wrongly writes the flag shows up by first setting the flag to the opposite of what the masked result would give. A wrong NaN or sign decision shows up as an incorrect flag on operand pairs chosen at each boundary: signed zeros, infinities, the largest finite value, and the smallest nonzero fraction.

// File: rtl/fp_cmp_flag.sv
module fp_cmp_flag #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic [3:0]                  cond,
  output logic                        cond_flag,
  output logic                        invalid_pulse
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SEL_UN = 0;
  localparam int SEL_EQ = 1;
  localparam int SEL_LT = 2;
  localparam int SEL_SG = 3;

  logic             a_sign, b_sign, a_nan, b_nan;
  logic [W-2:0]     a_mag, b_mag;
  logic             unord, both_zero, lt_raw, below, equal, trap, flag_next;

  assign a_sign = op_a[W-1];
  assign b_sign = op_b[W-1];
  assign a_mag  = op_a[W-2:0];
  assign b_mag  = op_b[W-2:0];
  assign a_nan  = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
  assign b_nan  = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
  assign unord  = a_nan | b_nan;

  assign both_zero = ~|a_mag && ~|b_mag;

  always_comb begin
    if (both_zero)            lt_raw = 1'b0;
    else if (a_sign != b_sign) lt_raw = a_sign;
    else if (a_sign)          lt_raw = a_mag > b_mag;
    else                      lt_raw = a_mag < b_mag;
  end

  assign below = !unord && lt_raw;
  assign equal = !unord && (both_zero || (op_a == op_b));
  assign trap  = cond[SEL_SG] && unord;

  assign flag_next = (cond[SEL_LT] && below) ||
                     (cond[SEL_EQ] && equal) ||
                     (cond[SEL_UN] && unord);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_flag     <= 1'b0;
      invalid_pulse <= 1'b0;
    end else begin
      invalid_pulse <= op_valid && trap;
      if (op_valid && !trap)
        cond_flag <= flag_next;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !cond_flag && !invalid_pulse);

  a_r6_trap_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cond[SEL_SG] && unord |=> invalid_pulse && $stable(cond_flag));

  a_r7_ordered_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !unord |=> !invalid_pulse);

  a_r5_un_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !cond[SEL_SG] && cond[SEL_UN] && unord |=> cond_flag);

  a_r5_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cond == 4'b0000 |=> !cond_flag);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cond_flag));

  a_r9_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_pulse |-> $past(op_valid));
endmodule

// File: tb/fp_cmp_flag_test.sv
module fp_cmp_flag_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] P1   = 32'h3F800000;
  localparam logic [31:0] P2   = 32'h40000000;
  localparam logic [31:0] N1   = 32'hBF800000;
  localparam logic [31:0] N2   = 32'hC0000000;
  localparam logic [31:0] PZ   = 32'h00000000;
  localparam logic [31:0] NZ   = 32'h80000000;
  localparam logic [31:0] PINF = 32'h7F800000;
  localparam logic [31:0] NINF = 32'hFF800000;
  localparam logic [31:0] PMAX = 32'h7F7FFFFF;
  localparam logic [31:0] QNAN = 32'h7FC00000;
  localparam logic [31:0] SNAN = 32'h7F800001;
  localparam logic [31:0] NNAN = 32'hFFC00000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0] cond = '0;
  logic cond_flag, invalid_pulse;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cmp_flag uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .cond(cond), .cond_flag(cond_flag), .invalid_pulse(invalid_pulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [3:0] c, input logic exp_flag, input logic exp_inv);
    @(negedge clk);
    op_a = a; op_b = b; cond = c; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    op_a = ~a; op_b = b ^ 32'h8000_0000; cond = ~c;
    check({req, " flag"}, cond_flag, exp_flag);
    check({req, " invalid"}, invalid_pulse, exp_inv);
    @(negedge clk);
    check({req, " R8 hold"}, cond_flag, exp_flag);
    check({req, " R9 pulse end"}, invalid_pulse, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 flag in reset", cond_flag, 1'b0);
    check("R1 invalid in reset", invalid_pulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after release", cond_flag, 1'b0);
    check("R1 invalid after release", invalid_pulse, 1'b0);
  endtask

  task automatic t_masks();
    cmp("R5 lt mask 1<2", P1, P2, 4'b0100, 1'b1, 1'b0);
    cmp("R5 eq mask 1<2", P1, P2, 4'b0010, 1'b0, 1'b0);
    cmp("R5 un mask 1<2", P1, P2, 4'b0001, 1'b0, 1'b0);
    cmp("R5 eq mask 2==2", P2, P2, 4'b0010, 1'b1, 1'b0);
    cmp("R5 empty mask", P2, P2, 4'b0000, 1'b0, 1'b0);
    cmp("R5 lt mask 2==2", P2, P2, 4'b0100, 1'b0, 1'b0);
    cmp("R5 le mask 2>1", P2, P1, 4'b0110, 1'b0, 1'b0);
    cmp("R5 le mask 1<=1", P1, P1, 4'b0110, 1'b1, 1'b0);
  endtask

  task automatic t_order();
    cmp("R3 -2<-1", N2, N1, 4'b0100, 1'b1, 1'b0);
    cmp("R3 -1 not< -2", N1, N2, 4'b0100, 1'b0, 1'b0);
    cmp("R3 -inf<-1", NINF, N1, 4'b0100, 1'b1, 1'b0);
    cmp("R3 max<+inf", PMAX, PINF, 4'b0100, 1'b1, 1'b0);
    cmp("R3 +inf==+inf", PINF, PINF, 4'b0010, 1'b1, 1'b0);
    cmp("R3 -1<1", N1, P1, 4'b0100, 1'b1, 1'b0);
    cmp("R3 1 not< -1", P1, N1, 4'b0100, 1'b0, 1'b0);
  endtask

  task automatic t_zeros();
    cmp("R4 +0==-0", PZ, NZ, 4'b0010, 1'b1, 1'b0);
    cmp("R4 -0 not< +0", NZ, PZ, 4'b0100, 1'b0, 1'b0);
    cmp("R4 -0 < 1", NZ, P1, 4'b0100, 1'b1, 1'b0);
  endtask

  task automatic t_nan();
    cmp("R2 qnan un", QNAN, P1, 4'b0001, 1'b1, 1'b0);
    cmp("R2 min-frac nan un", P1, SNAN, 4'b0001, 1'b1, 1'b0);
    cmp("R2 nan lt/eq false", QNAN, QNAN, 4'b0110, 1'b0, 1'b0);
    cmp("R2 inf not nan", PINF, P1, 4'b0001, 1'b0, 1'b0);
    cmp("R2 neg nan un", P1, NNAN, 4'b0001, 1'b1, 1'b0);
  endtask

  task automatic t_trap();
    cmp("R6 prime flag 1", P1, P2, 4'b0100, 1'b1, 1'b0);
    cmp("R6 trap keeps 1", QNAN, P1, 4'b1110, 1'b1, 1'b1);
    cmp("R6 prime flag 0", P2, P1, 4'b0100, 1'b0, 1'b0);
    cmp("R6 trap keeps 0 with un", P1, SNAN, 4'b1001, 1'b0, 1'b1);
    cmp("R7 ordered signalling lt", P1, P2, 4'b1100, 1'b1, 1'b0);
    cmp("R7 ordered signalling eq", N1, N1, 4'b1010, 1'b1, 1'b0);
  endtask

  task automatic t_idle();
    cmp("R8 prime flag 1", PZ, PZ, 4'b0010, 1'b1, 1'b0);
    @(negedge clk);
    op_a = P2; op_b = P1; cond = 4'b0100;
    repeat (4) @(negedge clk);
    check("R8 flag held while idle", cond_flag, 1'b1);
    check("R9 no pulse while idle", invalid_pulse, 1'b0);
    op_a = QNAN; cond = 4'b1000;
    repeat (2) @(negedge clk);
    check("R9 no pulse from idle trap inputs", invalid_pulse, 1'b0);
  endtask

  initial begin
    t_reset();
    t_masks();
    t_order();
    t_zeros();
    t_nan();
    t_trap();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule